// File: doc/BRIEF.md
# Field-Counted Video Channel Sequencer

This block selects which camera feeds an external analog video multiplexer. It drives a binary channel select and counts video fields by watching the vertical sync. In automatic mode it dwells a fixed number of fields on each channel and then steps to the next one, wrapping after the last channel. A host can also force a channel at any time by writing its number to a command register on a simple address/data bus. The same bus holds a control register for the run and automatic bits and a read-only status word.

The old and new sources are generally not field-aligned. For this reason a capture-enable output is held low for the first field of every newly selected channel, and for the first field after the sequencer starts. Capture resumes on the second field. The block also latches the field parity at the start of every field and drives it out as a tag. Downstream storage uses the tag to keep odd and even fields in separate regions. Vertical sync and parity come from another clock domain, so both pass through a two-stage synchronizer.

Top module: `field_channel_sequencer`

## Requirements
- R1: After reset, the select is 0, capture-enable is low, the field tag is 0, and both the control register (address 1) and the status word (address 2) read 0.
- R2: A write to address 0 with a value below the channel count (24) changes the select to that value on the next clock edge. A write of 24 or more leaves the select and the status word unchanged.
- R3: Field counting starts only at the first vertical-sync rising edge seen while the run bit (control bit 0) is 1. While run is 0, capture-enable is low and the status "live" bit (bit 15) is 0.
- R4: With run = 1 and the auto bit (control bit 1) = 1, the select advances by one after every 6 fields, and wraps from 23 to 0.
- R5: After an automatic switch, capture-enable is low during the first field of the new channel and high from its second field onward. The first field after a start is blanked in the same way.
- R6: A valid channel write while live drops capture-enable on the next edge. Capture-enable stays low until the second vertical-sync rise after the write. The dwell count restarts at the first of those rises.
- R7: With auto = 0, the select changes only on a host write. In this mode the field count saturates at 5.
- R8: At every vertical-sync rise, the field tag takes the synchronized parity input (1 = odd). Outputs respond on the third clock edge after the sync input rises.
- R9: The status word holds the select in bits [4:0], the field count within the dwell in bits [10:8], a busy bit in bit 14 (live with blanking pending) and the live bit in bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| field_par_in | input | 1 | Field parity, 1 = odd field |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 2 | Host register address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for bus_addr |
| mux_sel | output | 5 | Binary select for the analog multiplexer |
| cap_en | output | 1 | Capture enable, low during unsettled fields |
| field_odd | output | 1 | Parity tag of the current field |

## Verification
The bench sweeps every 5-bit command value. An off-by-one range check would either let 24 through or reject 23. It then runs the automatic sequence through more than one full wrap. A design that counted 5 or 7 fields, or wrapped to 24, would drift from the bench's arithmetic channel and blanking model within one dwell. A host write in the middle of a field tests the two-rise blanking rule: a design that reused the automatic one-field rule would enable capture one field early. Manual mode and stopping check that the select holds and that capture is cut off.

// File: rtl/vidseq_pkg.sv
// Shared register map and settle-state encoding for the video channel sequencer.
// Assumes a 2-bit register address and a 16-bit host data path.
package vidseq_pkg;
    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CTRL_RUN     = 0;
    localparam int CTRL_AUTO    = 1;
    localparam int STAT_CNT_LSB = 8;
    localparam int STAT_BUSY    = 14;
    localparam int STAT_LIVE    = 15;

    // Number of vertical-sync rises still to pass before capture is valid.
    typedef enum logic [1:0] {
        SETTLE_NONE = 2'd0,
        SETTLE_ONE  = 2'd1,
        SETTLE_TWO  = 2'd2
    } settle_e;
endpackage

// File: rtl/vidseq_vsync_sync.sv
// Synchronizes vertical sync and field parity into the pixel clock domain and
// emits a one-cycle pulse on each sync rising edge, with the parity aligned.
// Assumes the sync pulse lasts at least two clocks.
module vidseq_vsync_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_in,
    input  logic par_in,
    output logic rise_o,
    output logic par_o
);
    logic [STAGES:0]   vs_q;
    logic [STAGES-1:0] par_q;

    // Shift both inputs through matched synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q  <= '0;
            par_q <= '0;
        end else begin
            vs_q  <= {vs_q[STAGES-1:0], vs_in};
            par_q <= {par_q[STAGES-2:0], par_in};
        end
    end

    assign rise_o = vs_q[STAGES-1] & ~vs_q[STAGES];
    assign par_o  = par_q[STAGES-1];

    // R8: the field-start pulse never lasts more than one cycle.
    assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/vidseq_host_regs.sv
// Host register file: channel command (write), control bits (read/write) and
// status word (read). Range-checks channel commands and discards bad ones.
module vidseq_host_regs
    import vidseq_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 5,
    parameter int CNT_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CH_W-1:0]   st_chan,
    input  logic [CNT_W-1:0]  st_cnt,
    input  logic              st_busy,
    input  logic              st_live,
    output logic              run,
    output logic              auto_mode,
    output logic              cmd_valid,
    output logic [CH_W-1:0]   cmd_chan
);
    logic cmd_in_range;

    // Hold the run and auto control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            auto_mode <= 1'b0;
        end else if (bus_wr && bus_addr == ADDR_CTRL) begin
            run       <= bus_wdata[CTRL_RUN];
            auto_mode <= bus_wdata[CTRL_AUTO];
        end
    end

    // Qualify a channel command by address and range.
    assign cmd_in_range = (bus_wdata < DATA_W'(NUM_CH));
    assign cmd_valid    = bus_wr && (bus_addr == ADDR_CMD) && cmd_in_range;
    assign cmd_chan     = bus_wdata[CH_W-1:0];

    // Build read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_RUN]  = run;
                bus_rdata[CTRL_AUTO] = auto_mode;
            end
            ADDR_STAT: begin
                bus_rdata[CH_W-1:0]              = st_chan;
                bus_rdata[STAT_CNT_LSB +: CNT_W] = st_cnt;
                bus_rdata[STAT_BUSY]             = st_busy;
                bus_rdata[STAT_LIVE]             = st_live;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R2: an accepted command always names an existing channel.
    assert_cmd_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (int'(cmd_chan) < NUM_CH));
endmodule

// File: rtl/vidseq_dwell_ctrl.sv
// Channel sequencer core: counts fields per channel, steps the channel in
// automatic mode, applies host commands and tracks the blanking of unsettled
// fields. A host command wins over a sync rise in the same cycle.
module vidseq_dwell_ctrl
    import vidseq_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int DWELL  = 6,
    parameter int CH_W   = 5,
    parameter int CNT_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            field_rise,
    input  logic            field_par,
    input  logic            run,
    input  logic            auto_mode,
    input  logic            cmd_valid,
    input  logic [CH_W-1:0] cmd_chan,
    output logic [CH_W-1:0] chan,
    output logic [CNT_W-1:0] cnt,
    output logic            live,
    output logic            busy,
    output logic            cap_en,
    output logic            field_odd
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL - 1);
    localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);

    settle_e settle;

    // Sequence channels, count fields and track the settle window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan   <= '0;
            cnt    <= '0;
            live   <= 1'b0;
            settle <= SETTLE_NONE;
        end else if (!run) begin
            live   <= 1'b0;
            cnt    <= '0;
            settle <= SETTLE_NONE;
            if (cmd_valid) chan <= cmd_chan;
        end else if (cmd_valid) begin
            chan <= cmd_chan;
            cnt  <= '0;
            if (live) settle <= SETTLE_TWO;
        end else if (field_rise) begin
            if (!live) begin
                live   <= 1'b1;
                cnt    <= '0;
                settle <= SETTLE_ONE;
            end else if (settle == SETTLE_TWO) begin
                settle <= SETTLE_ONE;
            end else if (auto_mode && cnt == CNT_LAST) begin
                chan   <= (chan == CH_LAST) ? '0 : chan + 1'b1;
                cnt    <= '0;
                settle <= SETTLE_ONE;
            end else begin
                if (cnt != CNT_LAST) cnt <= cnt + 1'b1;
                settle <= SETTLE_NONE;
            end
        end
    end

    // Latch the parity tag at the start of every field.
    always_ff @(posedge clk) begin
        if (!rst_n)          field_odd <= 1'b0;
        else if (field_rise) field_odd <= field_par;
    end

    assign cap_en = live && (settle == SETTLE_NONE);
    assign busy   = live && (settle != SETTLE_NONE);

    // R4: select and dwell count stay in range.
    assert_chan_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chan) < NUM_CH);
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);
    // R5: no capture in the cycle a live channel change takes effect.
    assert_blank_on_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(live) && chan != $past(chan)) |-> !cap_en);
    // R7: manual mode never moves the select without a command.
    assert_manual_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !auto_mode && !cmd_valid) |=> $stable(chan));
    // R3: stopping cuts capture off.
    assert_stopped_no_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !cap_en);
endmodule

// File: rtl/field_channel_sequencer.sv
// Top level of the field-counted video channel sequencer: sync front end,
// host registers and the dwell/blanking core. Assumes vsync and parity are
// asynchronous to clk and that the host bus is synchronous to clk.
module field_channel_sequencer
    import vidseq_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int DWELL  = 6,
    parameter int DATA_W = 16,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int CNT_W  = $clog2(DWELL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_in,
    input  logic              field_par_in,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CH_W-1:0]   mux_sel,
    output logic              cap_en,
    output logic              field_odd
);
    logic             field_rise;
    logic             field_par;
    logic             run;
    logic             auto_mode;
    logic             cmd_valid;
    logic [CH_W-1:0]  cmd_chan;
    logic [CNT_W-1:0] cnt;
    logic             live;
    logic             busy;

    vidseq_vsync_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .vs_in  (vsync_in),
        .par_in (field_par_in),
        .rise_o (field_rise),
        .par_o  (field_par)
    );

    vidseq_host_regs #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .st_chan   (mux_sel),
        .st_cnt    (cnt),
        .st_busy   (busy),
        .st_live   (live),
        .run       (run),
        .auto_mode (auto_mode),
        .cmd_valid (cmd_valid),
        .cmd_chan  (cmd_chan)
    );

    vidseq_dwell_ctrl #(
        .NUM_CH(NUM_CH), .DWELL(DWELL), .CH_W(CH_W), .CNT_W(CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_rise (field_rise),
        .field_par  (field_par),
        .run        (run),
        .auto_mode  (auto_mode),
        .cmd_valid  (cmd_valid),
        .cmd_chan   (cmd_chan),
        .chan       (mux_sel),
        .cnt        (cnt),
        .live       (live),
        .busy       (busy),
        .cap_en     (cap_en),
        .field_odd  (field_odd)
    );
endmodule

// File: tb/field_channel_sequencer_tb.sv
`timescale 1ns/1ps
module field_channel_sequencer_tb;
    localparam int NUM_CH = 24;
    localparam int DWELL  = 6;
    localparam int FIELD  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync_in = 1'b0;
    logic        field_par_in = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [4:0]  mux_sel;
    logic        cap_en;
    logic        field_odd;

    int n_checks = 0;
    int n_fail = 0;

    // Reference model state, driven only by the requirements.
    int m_chan = 0, m_cnt = 0, m_settle = 0;
    bit m_live = 0, m_run = 0, m_auto = 0, m_odd = 0;

    always #2.5 clk = ~clk;

    field_channel_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .field_par_in(field_par_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mux_sel(mux_sel), .cap_en(cap_en), .field_odd(field_odd)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input int d);
        bus_addr = a; bus_wdata = 16'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic model_cmd(input int v);
        if (v < NUM_CH) begin
            m_chan = v;
            if (m_run) begin
                m_cnt = 0;
                if (m_live) m_settle = 2;
            end
        end
    endtask

    task automatic model_ctrl(input int v);
        m_run = v[0]; m_auto = v[1];
        if (!m_run) begin m_live = 0; m_cnt = 0; m_settle = 0; end
    endtask

    task automatic model_rise(input bit odd);
        m_odd = odd;
        if (!m_run) return;
        if (!m_live) begin
            m_live = 1; m_cnt = 0; m_settle = 1;
        end else if (m_settle == 2) begin
            m_settle = 1;
        end else if (m_auto && m_cnt == DWELL - 1) begin
            m_chan = (m_chan + 1) % NUM_CH; m_cnt = 0; m_settle = 1;
        end else begin
            if (m_cnt != DWELL - 1) m_cnt++;
            m_settle = 0;
        end
    endtask

    function automatic int exp_status();
        return m_chan | (m_cnt << 8) | (int'(m_live && m_settle != 0) << 14) | (int'(m_live) << 15);
    endfunction

    // One field: sync rise, check after the 3-edge latency, then the rest of the field.
    task automatic do_field(input bit odd, input string req);
        int st;
        field_par_in = odd; vsync_in = 1'b1;
        repeat (4) @(negedge clk);
        model_rise(odd);
        check({req, " select"}, int'(mux_sel), m_chan);
        check({req, " capture"}, int'(cap_en), int'(m_live && m_settle == 0));
        check("R8 field tag", int'(field_odd), int'(m_odd));
        bus_read(2'd2, st);
        check("R9 status", st, exp_status());
        vsync_in = 1'b0;
        repeat (FIELD - 4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 select", int'(mux_sel), 0);
        check("R1 capture", int'(cap_en), 0);
        check("R1 field tag", int'(field_odd), 0);
        bus_read(2'd1, rd); check("R1 ctrl", rd, 0);
        bus_read(2'd2, rd); check("R1 status", rd, 0);

        // R3: stopped, sync edges do not start counting
        for (int f = 0; f < 3; f++) do_field(f[0], "R3");

        // R2: sweep every 5-bit command value while stopped
        for (int v = 0; v < 32; v++) begin
            bus_write(2'd0, v);
            model_cmd(v);
            check("R2 sweep select", int'(mux_sel), m_chan);
            bus_read(2'd2, rd); check("R2 sweep status", rd, exp_status());
        end

        // R4/R5: automatic run from channel 22 through more than a full wrap
        bus_write(2'd0, 22); model_cmd(22);
        bus_write(2'd1, 3);  model_ctrl(3);
        bus_read(2'd1, rd); check("R3 ctrl readback", rd, 3);
        check("R3 not live before sync", int'(cap_en), 0);
        for (int f = 0; f < NUM_CH * DWELL + 10; f++) do_field(f[0], "R4 R5");

        // R6: host switch mid-field, then a rejected command
        repeat (3) @(negedge clk);
        bus_write(2'd0, 5); model_cmd(5);
        check("R6 select", int'(mux_sel), 5);
        check("R6 capture dropped", int'(cap_en), 0);
        bus_write(2'd0, 27); model_cmd(27);
        check("R2 reject while live", int'(mux_sel), 5);
        bus_read(2'd2, rd); check("R2 status unchanged", rd, exp_status());
        for (int f = 0; f < 14; f++) do_field(f[0], "R6");

        // R7: manual mode holds the channel
        bus_write(2'd1, 1); model_ctrl(1);
        for (int f = 0; f < 15; f++) do_field(!f[0], "R7");
        bus_write(2'd0, 23); model_cmd(23);
        check("R7 manual command", int'(mux_sel), 23);
        for (int f = 0; f < 4; f++) do_field(f[0], "R7");

        // R3: stopping cuts capture and clears live
        bus_write(2'd1, 0); model_ctrl(0);
        @(negedge clk);
        check("R3 stop capture", int'(cap_en), 0);
        bus_read(2'd2, rd); check("R3 stop status", rd, exp_status());
        do_field(1'b1, "R3");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule